// File: doc/BRIEF.md
# Command Word Packet Framer

This block sits between a producer of 32-bit command words and a rendering pipeline. Words arrive over a valid/ready input. The top byte of the first word of each packet is its opcode, and the opcode fixes how many words the packet has. The framer gathers the words in a small buffer. Once the final word has arrived, it replays the packet one word per cycle to the renderer, with flags that mark the first and last words. While a packet is being replayed, the input is held off.

As each packet completes, the block also updates its eight environment registers. Setting commands write a whole word into one register. Textured polygon packets rewrite the low nine bits of register 1 from one of their vertex words. A 13-bit status word is built from register 1 and register 6, and the full environment is presented to the renderer.

Two opcodes start a memory rectangle transfer. They are not forwarded as packets. Instead their position and size words go to a transfer engine, together with a one-cycle start pulse and a read/write flag. From then on every input word bypasses framing and goes to the transfer engine, until that engine signals completion.

Top module: `cmd_framer`

## Requirements
- R1: A packet has 1 + E words, where E is selected by bits 31:24 of its first word:
  - 0x02 → 2
  - 0x20–23 → 3, 0x24–27 → 6, 0x28–2B → 4, 0x2C–2F → 8
  - 0x30–33 → 5, 0x34–37 → 8, 0x38–3B → 7, 0x3C–3F → 11
  - 0x40–43 → 2, 0x48–4F → 3, 0x50–53 → 3, 0x58–5F → 4
  - 0x60–63 → 2, 0x64–67 → 3, 0x68–6B → 1, 0x6C–6F → 2
  - 0x70–73 → 1, 0x74–77 → 2, 0x78–7B → 1, 0x7C–7F → 2
  - 0x80 → 3, 0xA0 → 2, 0xC0 → 2
  - any other opcode → 0

  A forwarded packet carries exactly that many words, in arrival order. `pkt_first` is high only on word 0 and `pkt_last` only on the final word.
- R2: No word of a packet appears on the packet output until every word of that packet has been accepted.
- R3: Forwarding starts in the cycle right after the final word is accepted and runs one word per cycle. `in_ready` is low while forwarding and high again in the cycle after the last word.
- R4: An opcode in 0xE0–0xE7 writes its whole first word into environment register (opcode & 7). Register k is visible on `env_state[32k+31:32k]` in the cycle after acceptance.
- R5: `status_low[10:0]` equals environment register 1 bits 10:0, and `status_low[12:11]` equals register 6 bits 1:0.
- R6: When (opcode & 0xF4) == 0x24, bits 8:0 of packet word 4 replace bits 8:0 of register 1. The other bits of register 1 are kept. Other polygon opcodes such as 0x28 leave register 1 unchanged.
- R7: When (opcode & 0xF4) == 0x34, bits 8:0 of packet word 5 replace bits 8:0 of register 1. Word 4 of such a packet has no effect.
- R8: Opcodes 0xA0 and 0xC0 are not forwarded. In the cycle after their third word, `xfer_start` is high for exactly one cycle, with:
  - `xfer_pos` = word 1
  - `xfer_size` = word 2
  - `xfer_read` = 1 for 0xC0 and 0 for 0xA0
- R9: After a transfer starts, `in_ready` stays high and each accepted word appears on `xfer_word` with `xfer_word_valid` in the same cycle, never on the packet output. A word accepted in the same cycle as `xfer_done` is still bypassed, and later words are framed again.
- R10: Synchronous reset clears all environment registers, the status and any partially gathered packet. The first word after reset is treated as a new opcode.
- R11: Opcodes with E = 0 (for example 0x00, 0x44, 0x90, 0xE3) are forwarded as single-word packets with both flags high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word present |
| in_data | input | DW | Command word |
| in_ready | output | 1 | Block accepts a word this cycle |
| pkt_valid | output | 1 | Packet word to renderer valid |
| pkt_data | output | DW | Packet word |
| pkt_first | output | 1 | First word of a packet |
| pkt_last | output | 1 | Last word of a packet |
| xfer_start | output | 1 | One-cycle start of a rectangle transfer |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | DW | Transfer position word |
| xfer_size | output | DW | Transfer size word |
| xfer_word_valid | output | 1 | Bypassed word to transfer engine valid |
| xfer_word | output | DW | Bypassed word |
| xfer_done | input | 1 | Transfer engine finished, resume framing |
| env_state | output | 8*DW | The eight environment registers, register k at bits 32k+31:32k |
| status_low | output | 13 | Status bits built from registers 1 and 6 |

## Verification
The transfer engine's completion signal can arrive in the same cycle as a bypassed data word. The bench raises `xfer_done` together with the last data word of a write transfer and also of a read transfer. It then checks two things: that word still reaches `xfer_word`, and the following single-word command is framed and forwarded instead of bypassed. A second coincidence is the completion of a packet and the update of the environment and status from that packet's own last word. This is judged by reading `status_low` and `env_state` in the cycle right after the final word of setting and textured packets.

// File: rtl/cmdf_pkg.sv
`timescale 1ns/1ps
package cmdf_pkg;

   localparam int OPW     = 8;
   localparam int ENV_N   = 8;
   localparam int STAT_W  = 13;
   localparam int MAX_PKT = 12;

   typedef enum logic [1:0] {
      MODE_COLLECT = 2'd0,
      MODE_DRAIN   = 2'd1,
      MODE_XFER    = 2'd2
   } mode_t;

   // extra words following the opcode word
   function automatic logic [3:0] extra_words(input logic [OPW-1:0] op);
      logic [3:0] r;
      r = 4'd0;
      case (op[7:2])
         6'h08: r = 4'd3;
         6'h09: r = 4'd6;
         6'h0A: r = 4'd4;
         6'h0B: r = 4'd8;
         6'h0C: r = 4'd5;
         6'h0D: r = 4'd8;
         6'h0E: r = 4'd7;
         6'h0F: r = 4'd11;
         6'h10: r = 4'd2;
         6'h12, 6'h13, 6'h14: r = 4'd3;
         6'h16, 6'h17: r = 4'd4;
         6'h18: r = 4'd2;
         6'h19: r = 4'd3;
         6'h1A, 6'h1C, 6'h1E: r = 4'd1;
         6'h1B, 6'h1D, 6'h1F: r = 4'd2;
         default: r = 4'd0;
      endcase
      if (op == 8'h02) r = 4'd2;
      if (op == 8'h80) r = 4'd3;
      if (op == 8'hA0 || op == 8'hC0) r = 4'd2;
      return r;
   endfunction

   function automatic logic is_xfer_op(input logic [OPW-1:0] op);
      return (op == 8'hA0) || (op == 8'hC0);
   endfunction

   function automatic logic is_env_op(input logic [OPW-1:0] op);
      return op[7:3] == 5'b11100;
   endfunction

   function automatic logic is_tex_flat(input logic [OPW-1:0] op);
      return (op & 8'hF4) == 8'h24;
   endfunction

   function automatic logic is_tex_shaded(input logic [OPW-1:0] op);
      return (op & 8'hF4) == 8'h34;
   endfunction

endpackage

// File: rtl/cmdf_collect.sv
`timescale 1ns/1ps
module cmdf_collect
   import cmdf_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 12
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      acc,
   input  logic [DW-1:0]             din,
   output logic [OPW-1:0]            op_o,
   output logic [$clog2(DEPTH+1)-1:0] len_o,
   output logic                      complete_o,
   output logic [DEPTH-1:0][DW-1:0]  view_o
);
   localparam int LW = $clog2(DEPTH + 1);

   logic [LW-1:0]            cnt_q;
   logic [OPW-1:0]           op_q;
   logic [DEPTH-1:0][DW-1:0] slot_q;
   logic                     at_head;

   assign at_head    = (cnt_q == '0);
   assign op_o       = at_head ? din[DW-1 -: OPW] : op_q;
   assign len_o      = LW'(extra_words(op_o)) + LW'(1);
   assign complete_o = acc && ((cnt_q + LW'(1)) == len_o);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         op_q  <= '0;
      end else if (acc) begin
         if (complete_o) cnt_q <= '0;
         else            cnt_q <= cnt_q + LW'(1);
         if (at_head)    op_q  <= din[DW-1 -: OPW];
      end
   end

   // one register per packet slot; the live view merges the word in flight
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic hit;
      assign hit = acc && (cnt_q == LW'(i));
      always_ff @(posedge clk) begin
         if (hit) slot_q[i] <= din;
      end
      assign view_o[i] = hit ? din : slot_q[i];
   end

endmodule

// File: rtl/cmdf_env.sv
`timescale 1ns/1ps
module cmdf_env
   import cmdf_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  upd,
   input  logic [OPW-1:0]        op,
   input  logic [DW-1:0]         w0,
   input  logic [8:0]            w4,
   input  logic [8:0]            w5,
   output logic [ENV_N*DW-1:0]   env_o,
   output logic [STAT_W-1:0]     status_o
);
   logic [ENV_N-1:0][DW-1:0] env_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         env_q <= '0;
      end else if (upd) begin
         if (is_env_op(op))
            env_q[op[2:0]] <= w0;
         else if (is_tex_flat(op))
            env_q[1][8:0] <= w4;
         else if (is_tex_shaded(op))
            env_q[1][8:0] <= w5;
      end
   end

   assign env_o    = env_q;
   assign status_o = {env_q[6][1:0], env_q[1][10:0]};

endmodule

// File: rtl/cmdf_drain.sv
`timescale 1ns/1ps
module cmdf_drain #(
   parameter int DW    = 32,
   parameter int DEPTH = 12
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       start,
   input  logic [$clog2(DEPTH+1)-1:0] len_i,
   input  logic [DEPTH-1:0][DW-1:0]   words_i,
   output logic                       valid_o,
   output logic [DW-1:0]              data_o,
   output logic                       first_o,
   output logic                       last_o
);
   localparam int LW = $clog2(DEPTH + 1);

   logic          busy_q;
   logic [LW-1:0] rd_q;
   logic [LW-1:0] len_q;
   logic          at_end;

   assign at_end = (rd_q == len_q - LW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         rd_q   <= '0;
         len_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         rd_q   <= '0;
         len_q  <= len_i;
      end else if (busy_q) begin
         if (at_end) busy_q <= 1'b0;
         else        rd_q   <= rd_q + LW'(1);
      end
   end

   assign valid_o = busy_q;
   assign data_o  = words_i[rd_q];
   assign first_o = busy_q && (rd_q == '0);
   assign last_o  = busy_q && at_end;

endmodule

// File: rtl/cmd_framer.sv
`timescale 1ns/1ps
module cmd_framer
   import cmdf_pkg::*;
#(
   parameter int DW       = 32,
   parameter int DEPTH    = MAX_PKT,
   parameter bit XFER_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [DW-1:0]         in_data,
   output logic                  in_ready,
   output logic                  pkt_valid,
   output logic [DW-1:0]         pkt_data,
   output logic                  pkt_first,
   output logic                  pkt_last,
   output logic                  xfer_start,
   output logic                  xfer_read,
   output logic [DW-1:0]         xfer_pos,
   output logic [DW-1:0]         xfer_size,
   output logic                  xfer_word_valid,
   output logic [DW-1:0]         xfer_word,
   input  logic                  xfer_done,
   output logic [ENV_N*DW-1:0]   env_state,
   output logic [STAT_W-1:0]     status_low
);
   localparam int LW = $clog2(DEPTH + 1);

   if (DW < 32) begin : g_bad_dw
      $error("cmd_framer: DW must be at least 32");
   end
   if (DEPTH < MAX_PKT) begin : g_bad_depth
      $error("cmd_framer: DEPTH must hold the longest packet");
   end

   mode_t                    mode_q;
   logic                     acc;
   logic [OPW-1:0]           op;
   logic [LW-1:0]            len;
   logic                     complete;
   logic [DEPTH-1:0][DW-1:0] view;
   logic                     xcmd;
   logic                     in_xfer;

   assign in_xfer  = (mode_q == MODE_XFER);
   assign in_ready = (mode_q == MODE_COLLECT) || in_xfer;
   assign acc      = in_valid && (mode_q == MODE_COLLECT);
   assign xcmd     = is_xfer_op(op);

   cmdf_collect #(.DW(DW), .DEPTH(DEPTH)) u_collect (
      .clk        (clk),
      .rst        (rst),
      .acc        (acc),
      .din        (in_data),
      .op_o       (op),
      .len_o      (len),
      .complete_o (complete),
      .view_o     (view)
   );

   cmdf_env #(.DW(DW)) u_env (
      .clk      (clk),
      .rst      (rst),
      .upd      (complete),
      .op       (op),
      .w0       (view[0]),
      .w4       (view[4][8:0]),
      .w5       (view[5][8:0]),
      .env_o    (env_state),
      .status_o (status_low)
   );

   cmdf_drain #(.DW(DW), .DEPTH(DEPTH)) u_drain (
      .clk     (clk),
      .rst     (rst),
      .start   (complete && !xcmd),
      .len_i   (len),
      .words_i (view),
      .valid_o (pkt_valid),
      .data_o  (pkt_data),
      .first_o (pkt_first),
      .last_o  (pkt_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_COLLECT;
      end else begin
         case (mode_q)
            MODE_COLLECT: if (complete) mode_q <= xcmd ? MODE_XFER : MODE_DRAIN;
            MODE_DRAIN:   if (pkt_last) mode_q <= MODE_COLLECT;
            MODE_XFER:    if (xfer_done) mode_q <= MODE_COLLECT;
            default:      mode_q <= MODE_COLLECT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         xfer_start <= 1'b0;
         xfer_read  <= 1'b0;
         xfer_pos   <= '0;
         xfer_size  <= '0;
      end else begin
         xfer_start <= complete && xcmd;
         if (complete && xcmd) begin
            xfer_read <= (op == 8'hC0);
            xfer_pos  <= view[1];
            xfer_size <= view[2];
         end
      end
   end

   if (XFER_REG) begin : g_bypass_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            xfer_word_valid <= 1'b0;
            xfer_word       <= '0;
         end else begin
            xfer_word_valid <= in_valid && in_xfer;
            xfer_word       <= in_data;
         end
      end
   end else begin : g_bypass_comb
      assign xfer_word_valid = in_valid && in_xfer;
      assign xfer_word       = in_data;
   end

endmodule

// File: rtl/cmdf_chk.sv
`timescale 1ns/1ps
module cmdf_chk (
   input logic clk,
   input logic rst,
   input logic in_ready,
   input logic pkt_valid,
   input logic pkt_first,
   input logic pkt_last,
   input logic xfer_start,
   input logic xfer_word_valid
);
   // R3
   drain_holds_input_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_valid |-> !in_ready);

   // R1
   first_opens_pkt_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pkt_valid) |-> pkt_first);

   // R1
   last_closes_pkt_chk: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid && pkt_last) |=> !pkt_valid);

   // R3
   pkt_continues_chk: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid && !pkt_last) |=> (pkt_valid && !pkt_first));

   // R8
   start_is_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_start |=> !xfer_start);

   // R9
   bypass_excl_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_word_valid |-> (in_ready && !pkt_valid));
endmodule

bind cmd_framer cmdf_chk u_chk (
   .clk             (clk),
   .rst             (rst),
   .in_ready        (in_ready),
   .pkt_valid       (pkt_valid),
   .pkt_first       (pkt_first),
   .pkt_last        (pkt_last),
   .xfer_start      (xfer_start),
   .xfer_word_valid (xfer_word_valid)
);

// File: tb/cmd_framer_test.sv
`timescale 1ns/1ps
module cmd_framer_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic xfer_done = 1'b0;
   logic in_ready, pkt_valid, pkt_first, pkt_last;
   logic [31:0] pkt_data;
   logic xfer_start, xfer_read, xfer_word_valid;
   logic [31:0] xfer_pos, xfer_size, xfer_word;
   logic [255:0] env_state;
   logic [12:0] status_low;

   always #2.5 clk = ~clk;

   cmd_framer uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_first(pkt_first), .pkt_last(pkt_last),
      .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
      .xfer_word_valid(xfer_word_valid), .xfer_word(xfer_word), .xfer_done(xfer_done),
      .env_state(env_state), .status_low(status_low)
   );

   int total = 0, bad = 0;
   int cyc = 0, last_acc = 0;
   int mon_n = 0, rdy_viol = 0, xn = 0, xs_n = 0;
   logic [31:0] mw [64];
   logic        mf [64];
   logic        ml [64];
   int          mc [64];
   logic [31:0] xw [16];
   logic [31:0] xs_pos, xs_size;
   logic        xs_read;
   logic [31:0] pw [16];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!rst) begin
         if (pkt_valid) begin
            if (mon_n < 64) begin
               mw[mon_n] = pkt_data; mf[mon_n] = pkt_first;
               ml[mon_n] = pkt_last; mc[mon_n] = cyc;
            end
            mon_n++;
            if (in_ready) rdy_viol++;
         end
         if (xfer_word_valid) begin
            if (xn < 16) xw[xn] = xfer_word;
            xn++;
         end
         if (xfer_start) begin
            xs_n++; xs_pos = xfer_pos; xs_size = xfer_size; xs_read = xfer_read;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_len(input logic [7:0] op);
      int e = 0;
      if (op == 8'h02) e = 2;
      else if (op >= 8'h20 && op <= 8'h23) e = 3;
      else if (op >= 8'h24 && op <= 8'h27) e = 6;
      else if (op >= 8'h28 && op <= 8'h2B) e = 4;
      else if (op >= 8'h2C && op <= 8'h2F) e = 8;
      else if (op >= 8'h30 && op <= 8'h33) e = 5;
      else if (op >= 8'h34 && op <= 8'h37) e = 8;
      else if (op >= 8'h38 && op <= 8'h3B) e = 7;
      else if (op >= 8'h3C && op <= 8'h3F) e = 11;
      else if (op >= 8'h40 && op <= 8'h43) e = 2;
      else if (op >= 8'h48 && op <= 8'h53) e = 3;
      else if (op >= 8'h58 && op <= 8'h5F) e = 4;
      else if (op >= 8'h60 && op <= 8'h7F) begin
         if (op[3]) e = op[2] ? 2 : 1;
         else e = op[2] ? ((op < 8'h70) ? 3 : 2) : ((op < 8'h70) ? 2 : 1);
      end
      else if (op == 8'h80) e = 3;
      else if (op == 8'hA0 || op == 8'hC0) e = 2;
      return 1 + e;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic put(input logic [31:0] w);
      in_valid = 1'b1; in_data = w;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      last_acc = cyc;
      in_valid = 1'b0;
   endtask

   task automatic fill(input logic [7:0] op);
      pw[0] = {op, 24'h000055};
      for (int k = 1; k < 16; k++) pw[k] = {8'(k), 24'h00ABC0 + 24'(k)};
   endtask

   task automatic send(input int n);
      for (int k = 0; k < n; k++) put(pw[k]);
   endtask

   task automatic clear_mon();
      mon_n = 0; rdy_viol = 0; xn = 0; xs_n = 0;
   endtask

   task automatic t_reset();
      chk("R10", "in_ready after reset", {31'd0, in_ready}, 32'd1);
      chk("R10", "pkt_valid after reset", {31'd0, pkt_valid}, 32'd0);
      chk("R10", "status after reset", {19'd0, status_low}, 32'd0);
      chk("R10", "xfer_start after reset", {31'd0, xfer_start}, 32'd0);
   endtask

   task automatic t_lengths();
      logic [7:0] ops [14] = '{8'h02, 8'h20, 8'h28, 8'h38, 8'h3C, 8'h4A, 8'h60,
                               8'h68, 8'h7C, 8'h80, 8'h00, 8'h44, 8'h90, 8'hE3};
      for (int i = 0; i < 14; i++) begin
         int n;
         n = exp_len(ops[i]);
         clear_mon();
         fill(ops[i]);
         send(n);
         idle(14);
         chk("R1", $sformatf("word count op %0h", ops[i]), 32'(mon_n), 32'(n));
         chk("R3", "first word timing", 32'(mc[0]), 32'(last_acc));
         chk("R3", "last word timing", 32'(mc[n-1]), 32'(last_acc + n - 1));
         chk("R3", "in_ready low while forwarding", 32'(rdy_viol), 32'd0);
         for (int k = 0; k < n; k++) begin
            chk("R1", "word data", mw[k], pw[k]);
            chk("R1", "first flag", {31'd0, mf[k]}, {31'd0, k == 0});
            chk("R1", "last flag", {31'd0, ml[k]}, {31'd0, k == n - 1});
         end
         if (n == 1) chk("R11", "single word packet", 32'(mon_n), 32'd1);
      end
   endtask

   task automatic t_partial();
      clear_mon();
      fill(8'h20);
      for (int k = 0; k < 3; k++) put(pw[k]);
      idle(6);
      chk("R2", "nothing before final word", 32'(mon_n), 32'd0);
      put(pw[3]);
      idle(6);
      chk("R2", "released after final word", 32'(mon_n), 32'd4);
   endtask

   task automatic t_env();
      for (int k = 0; k < 8; k++) begin
         logic [31:0] w;
         w = {8'hE0 + 8'(k), 24'h111111 * 24'(k)};
         put(w);
         chk("R4", $sformatf("env reg %0d", k), env_state[32*k +: 32], w);
         idle(2);
      end
      chk("R5", "status from env1/env6", {19'd0, status_low}, 32'h1111);
      fill(8'h24); pw[4] = 32'h0000_0123; send(7);
      chk("R6", "flat textured env1", env_state[63:32], 32'hE111_1123);
      chk("R5", "status after flat", {19'd0, status_low}, 32'h1123);
      idle(10);
      fill(8'h34); pw[4] = 32'h0000_01FF; pw[5] = 32'h0000_00AA; send(9);
      chk("R7", "shaded textured env1", env_state[63:32], 32'hE111_10AA);
      chk("R7", "status after shaded", {19'd0, status_low}, 32'h10AA);
      idle(12);
      fill(8'h2C); pw[4] = 32'h0000_0055; send(9);
      chk("R6", "0x2C uses word 4", env_state[63:32], 32'hE111_1055);
      idle(12);
      fill(8'h28); pw[4] = 32'h0000_01FF; send(5);
      chk("R6", "untextured leaves env1", env_state[63:32], 32'hE111_1055);
      chk("R5", "status unchanged", {19'd0, status_low}, 32'h1055);
      idle(8);
   endtask

   task automatic t_xfer(input logic [7:0] op, input int nw);
      clear_mon();
      put({op, 24'h0});
      put(32'h0010_0020 + 32'(op));
      put(32'h0004_0008);
      idle(2);
      chk("R8", "start pulses once", 32'(xs_n), 32'd1);
      chk("R8", "position word", xs_pos, 32'h0010_0020 + 32'(op));
      chk("R8", "size word", xs_size, 32'h0004_0008);
      chk("R8", "direction", {31'd0, xs_read}, {31'd0, op == 8'hC0});
      chk("R8", "command not forwarded", 32'(mon_n), 32'd0);
      chk("R9", "in_ready during transfer", {31'd0, in_ready}, 32'd1);
      for (int k = 0; k < nw; k++) begin
         if (k == nw - 1) xfer_done = 1'b1;
         put(32'h0000_5A00 + 32'(k));
         xfer_done = 1'b0;
      end
      put(32'h0000_0000);
      idle(4);
      chk("R9", "bypassed word count", 32'(xn), 32'(nw));
      for (int k = 0; k < nw; k++)
         chk("R9", "bypassed word", xw[k], 32'h0000_5A00 + 32'(k));
      chk("R9", "framing resumes", 32'(mon_n), 32'd1);
      chk("R9", "resumed word", mw[0], 32'h0000_0000);
   endtask

   task automatic t_reset_mid();
      put(32'hE100_0333);
      idle(2);
      fill(8'h28);
      put(pw[0]); put(pw[1]);
      clear_mon();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      chk("R10", "status cleared", {19'd0, status_low}, 32'd0);
      chk("R10", "env cleared", env_state[63:32], 32'd0);
      chk("R10", "ready after reset", {31'd0, in_ready}, 32'd1);
      put(32'h9000_0001);
      idle(4);
      chk("R10", "partial packet dropped", 32'(mon_n), 32'd1);
      chk("R10", "new opcode word", mw[0], 32'h9000_0001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      t_reset();
      t_lengths();
      t_partial();
      t_env();
      t_xfer(8'hA0, 3);
      t_xfer(8'hC0, 1);
      t_reset_mid();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule